// File: doc/BRIEF.md
# DAC Command Decoder and Power Control

This block sits behind the serial shifter of a 12-bit voltage-output converter. It receives a complete 16-bit command word together with a one-cycle valid strobe and decodes it into actions on a two-stage data path. The first stage is a staging register. The second stage is the register that drives the converter. The block also keeps the shutdown state, a general-purpose output level that software controls, and a setting that selects which serial clock edge launches readback data.

Four asynchronous pins also steer the block:

- a clear pin, active low;
- a static pin that picks the clear value, which is either zero or midscale;
- a power-down request pin;
- a lockout pin. Shutdown can only begin while the lockout pin is high. A falling edge on the lockout pin wakes the block.

The clear, request and lockout pins pass through synchronizers inside the block. Edge detectors then act on the synchronized copies.

Shutdown keeps every register intact, and commands are still decoded while the block is in shutdown. The output-enable signal is low for as long as shutdown lasts, which tells the analog stage to float its output.

Top module: `dac_cmd_top`

## Requirements
- R1: After reset, with `clrN` high, the outputs settle to the following values: `dacCode` holds the clear value, `outEnable` is 1, `userOut` is 0 and `launchRise` is 0. The clear value is 0 when `rstMid` is 0 and 0x800 when `rstMid` is 1.
- R2: A command word has three fields. The opcode is in bits [15:13], the data is in bits [12:1], and bit 0 is ignored. Opcode 000 has no effect, and neither does opcode 111 with data bits [11:10] equal to 01.
- R3: Opcode 001 writes the data field into the staging register and leaves `dacCode` unchanged.
- R4: Opcode 010 writes the data field into both registers and leaves shutdown.
- R5: Opcode 011 copies the staging register into the output register and leaves shutdown.
- R6: Opcode 100 enters shutdown (`outEnable` = 0) only while `pdAllow` is high. While `pdAllow` is low, no source can start shutdown.
- R7: Opcode 110 drives `userOut` high and opcode 101 drives it low.
- R8: Opcode 111 with data bit 11 = 1 sets `launchRise` to 1. Opcode 111 with data bits [11:10] = 00 sets `launchRise` to 0.
- R9: While `clrN` is low, both registers load the clear value, shutdown ends and `userOut` goes to 0. Any command issued while `clrN` is low is ignored.
- R10: A rising edge on `pdReq` enters shutdown when `pdAllow` is high. A later fall of `pdReq` does not end shutdown.
- R11: A falling edge on `pdAllow` ends shutdown, and `dacCode` keeps the value it had before shutdown began.
- R12: Commands are still decoded during shutdown. Both registers and `userOut` keep their values unless a command changes them.
- R13: The effect of a command appears on the outputs at the clock edge that samples `cmdValid`. The effect of a pin change appears three clock edges after the pin moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | One-cycle strobe marking a complete command word |
| cmdWord | input | 16 | Command word: opcode, data, ignored sub-bit |
| clrN | input | 1 | Asynchronous clear request, active low |
| rstMid | input | 1 | Static select for the clear value: 0 gives zero, 1 gives midscale |
| pdReq | input | 1 | Asynchronous power-down request; a rising edge acts |
| pdAllow | input | 1 | Shutdown permit; a falling edge wakes the block |
| dacCode | output | 12 | Output register value sent to the converter |
| outEnable | output | 1 | High outside shutdown; low means the analog output floats |
| userOut | output | 1 | General-purpose output level set by command |
| launchRise | output | 1 | Readback edge select: 1 = rising edge, 0 = falling edge |

## Verification
The bench builds the block with its default values: a 12-bit data field and two synchronizer stages. With a 12-bit data field, the midscale clear value is 0x800, the codes 0xFFF and 0x000 appear at the edges of the range, and the edge-select decode reads word bits 12 and 11. With two synchronizer stages, every pin takes effect a fixed three edges after it moves, so the bench can sample each pin-driven change on an exact cycle. A reference model in the bench tracks both registers, shutdown and the two control bits for every opcode, both in and out of shutdown. Clear and command collisions are included.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  localparam int CTRL_W = 3;

  typedef enum logic [CTRL_W-1:0] {
    OP_NOP       = 3'b000,
    OP_LOAD_IN   = 3'b001,
    OP_LOAD_BOTH = 3'b010,
    OP_XFER      = 3'b011,
    OP_SLEEP     = 3'b100,
    OP_UPO_LO    = 3'b101,
    OP_UPO_HI    = 3'b110,
    OP_MODE      = 3'b111
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic loadIn;
    logic loadDac;
    logic copyDac;
  } dp_strobe_t;

endpackage

// File: rtl/dac_cmd_sync.sv
module dac_cmd_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= {STAGES{RESET_VAL[b]}};
      end else begin
        chain[0] <= din[b];
        for (int s = 1; s < STAGES; s++) begin
          chain[s] <= chain[s-1];
        end
      end
    end
    assign dout[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int WORD_W = CTRL_W + DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic              clrSyncN,
  input  logic              pdReqSync,
  input  logic              pdAllowSync,
  output dp_strobe_t        strobe,
  output logic [DATA_W-1:0] cmdData,
  output logic              shutdown,
  output logic              userOut,
  output logic              launchRise
);

  localparam int OP_MSB = WORD_W - 1;

  opcode_e opcode;
  logic clearNow, cmdGo;
  logic pdReqPrev, pdAllowPrev;
  logic pdReqRise, allowFall;
  logic wakeCmd, sleepCmd, upoSet, upoClr, modeSet, modeClr;

  assign opcode    = opcode_e'(cmdWord[OP_MSB -: CTRL_W]);
  assign cmdData   = cmdWord[DATA_W:1];
  assign clearNow  = ~clrSyncN;
  assign cmdGo     = cmdValid & ~clearNow;
  assign pdReqRise = pdReqSync & ~pdReqPrev;
  assign allowFall = pdAllowPrev & ~pdAllowSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdReqPrev   <= 1'b0;
      pdAllowPrev <= 1'b0;
    end else begin
      pdReqPrev   <= pdReqSync;
      pdAllowPrev <= pdAllowSync;
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.clear = clearNow;
    wakeCmd  = 1'b0;
    sleepCmd = 1'b0;
    upoSet   = 1'b0;
    upoClr   = 1'b0;
    modeSet  = 1'b0;
    modeClr  = 1'b0;
    if (cmdGo) begin
      case (opcode)
        OP_LOAD_IN: strobe.loadIn = 1'b1;
        OP_LOAD_BOTH: begin
          strobe.loadIn  = 1'b1;
          strobe.loadDac = 1'b1;
          wakeCmd        = 1'b1;
        end
        OP_XFER: begin
          strobe.copyDac = 1'b1;
          wakeCmd        = 1'b1;
        end
        OP_SLEEP:  sleepCmd = 1'b1;
        OP_UPO_LO: upoClr   = 1'b1;
        OP_UPO_HI: upoSet   = 1'b1;
        OP_MODE: begin
          if (cmdData[DATA_W-1])      modeSet = 1'b1;
          else if (!cmdData[DATA_W-2]) modeClr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shutdown   <= 1'b0;
      userOut    <= 1'b0;
      launchRise <= 1'b0;
    end else begin
      if (clearNow)                                   shutdown <= 1'b0;
      else if (wakeCmd || allowFall)                  shutdown <= 1'b0;
      else if ((sleepCmd || pdReqRise) && pdAllowSync) shutdown <= 1'b1;

      if (clearNow)    userOut <= 1'b0;
      else if (upoSet) userOut <= 1'b1;
      else if (upoClr) userOut <= 1'b0;

      if (modeSet)      launchRise <= 1'b1;
      else if (modeClr) launchRise <= 1'b0;
    end
  end

  // R6: shutdown never starts while the permit is low
  assert_shut_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!shutdown && !pdAllowSync) |=> !shutdown);

  // R9: clear always leaves shutdown and drops the user output
  assert_clear_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clrSyncN |=> (!shutdown && !userOut));

  // R11: permit falling edge always wakes
  assert_allow_wake_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pdAllowPrev && !pdAllowSync) |=> !shutdown);

  // R12: user output holds in shutdown without a command touching it
  assert_upo_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (shutdown && clrSyncN && !cmdValid) |=> $stable(userOut));

endmodule

// File: rtl/dac_cmd_datapath.sv
module dac_cmd_datapath
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              rstMid,
  output logic [DATA_W-1:0] dacCode
);

  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] inputReg, dacReg, resetValue;

  assign resetValue = rstMid ? MID_CODE : '0;
  assign dacCode    = dacReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inputReg <= '0;
    end else if (strobe.clear) begin
      inputReg <= resetValue;
    end else if (strobe.loadIn) begin
      inputReg <= cmdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacReg <= '0;
    end else if (strobe.clear) begin
      dacReg <= resetValue;
    end else if (strobe.loadDac) begin
      dacReg <= cmdData;
    end else if (strobe.copyDac) begin
      dacReg <= inputReg;
    end
  end

  // R3: staging-only load leaves the output register alone
  assert_stage_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadIn && !strobe.loadDac && !strobe.clear) |=> $stable(dacReg));

  // R5: transfer moves the previous staging value
  assert_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.copyDac && !strobe.clear) |=> (dacReg == $past(inputReg)));

  // R9: clear lands the selected clear value in both registers
  assert_clear_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (dacReg == $past(resetValue) && inputReg == $past(resetValue)));

endmodule

// File: rtl/dac_cmd_top.sv
module dac_cmd_top
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = CTRL_W + DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [WORD_W-1:0] cmdWord,
  input  logic              clrN,
  input  logic              rstMid,
  input  logic              pdReq,
  input  logic              pdAllow,
  output logic [DATA_W-1:0] dacCode,
  output logic              outEnable,
  output logic              userOut,
  output logic              launchRise
);

  logic [2:0] pinSync;
  logic clrSyncN, pdReqSync, pdAllowSync, shutdown;
  dp_strobe_t strobe;
  logic [DATA_W-1:0] cmdData;

  // clear chain resets active so power-up performs a clear
  dac_cmd_sync #(.N(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b000)) u_sync (
    .clk(clk), .rstN(rstN), .din({clrN, pdReq, pdAllow}), .dout(pinSync)
  );
  assign {clrSyncN, pdReqSync, pdAllowSync} = pinSync;

  dac_cmd_ctrl #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .clrSyncN(clrSyncN), .pdReqSync(pdReqSync), .pdAllowSync(pdAllowSync),
    .strobe(strobe), .cmdData(cmdData), .shutdown(shutdown),
    .userOut(userOut), .launchRise(launchRise)
  );

  dac_cmd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdData(cmdData),
    .rstMid(rstMid), .dacCode(dacCode)
  );

  assign outEnable = ~shutdown;

endmodule

// File: tb/dac_cmd_top_bench.sv
module dac_cmd_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic clrN = 1'b1, rstMid = 1'b0, pdReq = 1'b0, pdAllow = 1'b1;
  logic [DW-1:0] dacCode;
  logic outEnable, userOut, launchRise;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model
  logic [DW-1:0] mIn, mDac;
  logic mShut, mUpo, mMode;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_top u_dac_cmd_top (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .clrN(clrN), .rstMid(rstMid), .pdReq(pdReq), .pdAllow(pdAllow),
    .dacCode(dacCode), .outEnable(outEnable), .userOut(userOut),
    .launchRise(launchRise)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "dacCode", int'(dacCode), int'(mDac));
    check(req, "outEnable", int'(outEnable), int'(!mShut));
    check(req, "userOut", int'(userOut), int'(mUpo));
    check(req, "launchRise", int'(launchRise), int'(mMode));
  endtask

  task automatic modelCmd(input logic [2:0] op, input logic [DW-1:0] d);
    case (op)
      3'b001: mIn = d;
      3'b010: begin mIn = d; mDac = d; mShut = 1'b0; end
      3'b011: begin mDac = mIn; mShut = 1'b0; end
      3'b100: if (pdAllow) mShut = 1'b1;
      3'b101: mUpo = 1'b0;
      3'b110: mUpo = 1'b1;
      3'b111: if (d[11]) mMode = 1'b1; else if (!d[10]) mMode = 1'b0;
      default: ;
    endcase
  endtask

  task automatic modelClear();
    mIn = rstMid ? 12'h800 : 12'h000;
    mDac = mIn; mShut = 1'b0; mUpo = 1'b0;
  endtask

  // drive one command; outputs change at the sampling edge (R13)
  task automatic sendCmd(input logic [2:0] op, input logic [DW-1:0] d, input logic sub, input string req);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord = {op, d, sub};
    @(negedge clk);
    cmdValid = 1'b0;
    cmdWord = '0;
    if (clrN) modelCmd(op, d);
    checkAll(req);
  endtask

  task automatic pinWait();
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    rstMid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mMode = 1'b0;
    modelClear();
    pinWait();
    checkAll("R1");
  endtask

  task automatic testLoads();
    sendCmd(3'b001, 12'hABC, 1'b0, "R3");
    sendCmd(3'b011, 12'h000, 1'b0, "R5");
    sendCmd(3'b010, 12'h123, 1'b1, "R4");
    sendCmd(3'b001, 12'h555, 1'b1, "R3");
    sendCmd(3'b000, 12'hFFF, 1'b1, "R2");
    sendCmd(3'b111, 12'h5FF, 1'b0, "R2");
    sendCmd(3'b011, 12'hFFF, 1'b0, "R5");
    sendCmd(3'b010, 12'hFFF, 1'b0, "R4");
  endtask

  task automatic testUpoMode();
    sendCmd(3'b110, 12'h000, 1'b0, "R7");
    sendCmd(3'b101, 12'hFFF, 1'b0, "R7");
    sendCmd(3'b111, 12'h800, 1'b0, "R8");
    sendCmd(3'b111, 12'h400, 1'b0, "R2");
    sendCmd(3'b111, 12'h3FF, 1'b0, "R8");
  endtask

  task automatic testSleepCmd();
    sendCmd(3'b110, 12'h000, 1'b0, "R7");
    sendCmd(3'b100, 12'h000, 1'b0, "R6");
    repeat (3) @(negedge clk);
    checkAll("R12");
    sendCmd(3'b001, 12'h0F0, 1'b0, "R12");
    sendCmd(3'b011, 12'h000, 1'b0, "R5");
    sendCmd(3'b100, 12'h000, 1'b0, "R6");
    sendCmd(3'b010, 12'h00F, 1'b0, "R4");
  endtask

  task automatic testBlocked();
    @(negedge clk); pdAllow = 1'b0;
    pinWait();
    sendCmd(3'b100, 12'h000, 1'b0, "R6");
    @(negedge clk); pdReq = 1'b1;
    pinWait();
    checkAll("R6");
    @(negedge clk); pdReq = 1'b0; pdAllow = 1'b1;
    pinWait();
    checkAll("R6");
  endtask

  task automatic testPinSleep();
    sendCmd(3'b010, 12'h6A5, 1'b0, "R4");
    @(negedge clk); pdReq = 1'b1;
    repeat (3) @(negedge clk);
    mShut = 1'b1;
    checkAll("R10");
    @(negedge clk); pdReq = 1'b0;
    pinWait();
    checkAll("R10");
    @(negedge clk); pdAllow = 1'b0;
    repeat (3) @(negedge clk);
    mShut = 1'b0;
    checkAll("R11");
    @(negedge clk); pdAllow = 1'b1;
    pinWait();
    checkAll("R11");
  endtask

  task automatic testClear();
    sendCmd(3'b111, 12'h800, 1'b0, "R8");
    sendCmd(3'b110, 12'h000, 1'b0, "R7");
    sendCmd(3'b100, 12'h000, 1'b0, "R6");
    @(negedge clk); rstMid = 1'b1; clrN = 1'b0;
    pinWait();
    modelClear();
    checkAll("R9");
    sendCmd(3'b010, 12'h321, 1'b0, "R9");
    @(negedge clk); clrN = 1'b1;
    pinWait();
    checkAll("R9");
    sendCmd(3'b011, 12'h000, 1'b0, "R9");
    @(negedge clk); rstMid = 1'b0; clrN = 1'b0;
    pinWait();
    modelClear();
    checkAll("R9");
    @(negedge clk); clrN = 1'b1;
    pinWait();
  endtask

  initial begin
    mIn = '0; mDac = '0; mShut = 1'b0; mUpo = 1'b0; mMode = 1'b0;
    testReset();
    testLoads();
    testUpoMode();
    testSleepCmd();
    testBlocked();
    testPinSleep();
    testClear();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule